// File: doc/BRIEF.md
# Aliased GPIO Port Register Bank

This block is the register side of a 16-pin general-purpose I/O port. A simple synchronous bus reads and writes seventeen 16-bit registers. Three of them hold state that software often changes one bit at a time: the pin data word and two interrupt mask words. Each of these three has three companion addresses. One clears bits, one sets bits and one flips bits, so a single write can change any group of bits without a read-modify-write sequence. The remaining registers are plain words. They hold pin direction, sense polarity, edge selection, dual-edge selection and input enable.

The pins are driven from the data word. Only pins marked as outputs are driven. A change pulse reports which driven pins actually changed value after a write. The mask words and the sense configuration words go out on ports to the interrupt sense logic, which is a separate block. Bus errors are reported combinationally in the cycle of the offending access. An access is in error when its size code is not 16-bit or when its offset lies outside the map. An access in error changes nothing.

Top module: `gpio_regbank`

## Requirements
- R1: A synchronous active-high reset clears every register to zero. After reset, pin_out, pin_oe, pin_chg, both mask outputs and all configuration outputs are 0.
- R2: Registers sit at byte offsets that are multiples of 4. The order is: data 0x00, mask A 0x10, mask B 0x20, direction 0x30, polarity 0x34, edge 0x38, both-edges 0x3C, input enable 0x40. A legal write to one of these offsets stores the write data. A legal read of one returns the stored value.
- R3: The clear alias of a word is at its base offset + 0x4 (0x04, 0x14, 0x24). A write there clears the base word's bits wherever the written value has a one, and leaves all other bits unchanged.
- R4: The set alias is at base + 0x8 (0x08, 0x18, 0x28). A write there ORs the written value into the base word.
- R5: The toggle alias is at base + 0xC (0x0C, 0x1C, 0x2C). A write there XORs the written value into the base word.
- R6: A read of any clear, set or toggle alias returns the current value of its base word.
- R7: Only size code 1 (16-bit) is legal. Codes 0, 2 and 3 raise bus_err in the same cycle as the access, at any offset, and a write with such a code changes no register.
- R8: A legal-size access raises bus_err in the same cycle, and a write changes no register, in either of two cases: the offset is not a multiple of 4, or the offset is above 0x40. An erroring read returns 0.
- R9: pin_oe equals the direction word (1 = output). pin_out carries the data bit on output pins and 0 on input pins.
- R10: pin_chg is valid for the one cycle after a legal write to the data word, to any of its aliases, or to the direction word. In that cycle, a bit is 1 exactly when the pin is an output under the new direction word and its data bit changed in that write. In every other cycle pin_chg is 0.
- R11: Mask A, mask B, polarity, edge, both-edges and input enable are presented unchanged on their output ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | Access size code, 1 = 16-bit |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| bus_err | output | 1 | Access error, same cycle |
| pin_out | output | 16 | Driven pin values |
| pin_oe | output | 16 | Pin output enables |
| pin_chg | output | 16 | Driven-value change pulse per pin |
| irq_mask_a | output | 16 | Interrupt mask A |
| irq_mask_b | output | 16 | Interrupt mask B |
| cfg_polar | output | 16 | Sense polarity word |
| cfg_edge | output | 16 | Edge-select word |
| cfg_both | output | 16 | Dual-edge select word |
| cfg_inen | output | 16 | Input-enable word |

## Verification
Directed sequences come first. They load known values and then apply clear, set and toggle writes whose set bits overlap the stored ones only partly. These sequences tell the three alias operations apart from each other and from a plain store. A direction change followed by a data toggle shows whether pin_chg is limited to output pins and to bits that really changed. Accesses with a wrong size, unaligned offsets and offsets past the map separate the error path from the legal decode. A long fixed-seed random mix of reads, writes and bad accesses then checks every read and every output against a bench model after each cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int PINS      = 16;
    localparam int OFS_W     = 7;
    localparam int NUM_GRP   = 3;
    localparam int NUM_CFG   = 5;
    localparam int NUM_REGS  = NUM_GRP * 4 + NUM_CFG;
    localparam logic [1:0] SIZE_HALF = 2'd1;

    typedef enum logic [1:0] {
        OP_STORE  = 2'd0,
        OP_CLEAR  = 2'd1,
        OP_SET    = 2'd2,
        OP_TOGGLE = 2'd3
    } alias_op_e;

    typedef struct packed {
        logic      hit;
        logic      is_grp;
        logic [1:0] grp;
        alias_op_e op;
        logic [2:0] cfg;
    } dec_t;

    // Index of the direction word inside the configuration bank.
    localparam logic [2:0] CFG_DIR = 3'd0;
endpackage

// File: rtl/gpio_decode.sv
module gpio_decode
    import gpio_bank_pkg::*;
#(
    parameter int AW = OFS_W
) (
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    input  logic [1:0]    size,
    output dec_t          dec,
    output logic          err,
    output logic          wr_ok
);
    localparam int IW = AW - 2;
    logic [IW-1:0] idx;
    logic          size_bad;

    assign idx = addr[AW-1:2];

    always_comb begin
        dec.hit    = (addr[1:0] == 2'b00) && (int'(idx) < NUM_REGS);
        dec.is_grp = int'(idx) < NUM_GRP * 4;
        dec.grp    = idx[3:2];
        dec.op     = alias_op_e'(idx[1:0]);
        dec.cfg    = 3'(int'(idx) - NUM_GRP * 4);
    end

    // Size is judged before the address: either fault yields the same flag.
    assign size_bad = (size != SIZE_HALF);
    assign err      = (wr | rd) & (size_bad | ~dec.hit);
    assign wr_ok    = wr & ~err;
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
    import gpio_bank_pkg::*;
#(
    parameter int W = PINS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  alias_op_e    op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    always_comb begin
        unique case (op)
            OP_STORE:  nxt = wdata;
            OP_CLEAR:  nxt = q & ~wdata;
            OP_SET:    nxt = q | wdata;
            default:   nxt = q ^ wdata;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= nxt;
    end

    a_r3_clear_drops_bits: assert property (@(posedge clk) disable iff (rst)
        (we && op == OP_CLEAR) |=> ((q & $past(wdata)) == '0) &&
                                   ((q | $past(wdata)) == ($past(q) | $past(wdata))));
    a_r4_set_adds_bits: assert property (@(posedge clk) disable iff (rst)
        (we && op == OP_SET) |=> (q == ($past(q) | $past(wdata))));
    a_r5_toggle_flips: assert property (@(posedge clk) disable iff (rst)
        (we && op == OP_TOGGLE) |=> ((q ^ $past(q)) == $past(wdata)));
    a_r7_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_bank_pkg::*;
#(
    parameter int W = PINS,
    parameter int N = NUM_CFG
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [2:0]   sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q [N]
);
    for (genvar i = 0; i < N; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)                          q[i] <= '0;
            else if (we && int'(sel) == i)    q[i] <= wdata;
        end
    end
endmodule

// File: rtl/gpio_out_change.sv
module gpio_out_change
    import gpio_bank_pkg::*;
#(
    parameter int W = PINS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         trig,
    input  logic [W-1:0] data,
    input  logic [W-1:0] dir,
    output logic [W-1:0] chg
);
    logic [W-1:0] prev;
    logic         armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev  <= '0;
            armed <= 1'b0;
        end else begin
            armed <= trig;
            if (trig) prev <= data;
        end
    end

    assign chg = armed ? ((data ^ prev) & dir) : '0;
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_bank_pkg::*;
#(
    parameter int W  = PINS,
    parameter int AW = OFS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_size,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    output logic          bus_err,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_oe,
    output logic [W-1:0]  pin_chg,
    output logic [W-1:0]  irq_mask_a,
    output logic [W-1:0]  irq_mask_b,
    output logic [W-1:0]  cfg_polar,
    output logic [W-1:0]  cfg_edge,
    output logic [W-1:0]  cfg_both,
    output logic [W-1:0]  cfg_inen
);
    dec_t         dec;
    logic         wr_ok;
    logic [W-1:0] grp_q [NUM_GRP];
    logic [W-1:0] cfg_q [NUM_CFG];
    logic         out_trig;

    gpio_decode #(.AW(AW)) u_dec (
        .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .size(bus_size),
        .dec(dec), .err(bus_err), .wr_ok(wr_ok)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        gpio_alias_reg #(.W(W)) u_reg (
            .clk(clk), .rst(rst),
            .we(wr_ok && dec.is_grp && int'(dec.grp) == g),
            .op(dec.op), .wdata(bus_wdata), .q(grp_q[g])
        );
    end

    gpio_cfg_bank #(.W(W), .N(NUM_CFG)) u_cfg (
        .clk(clk), .rst(rst), .we(wr_ok && !dec.is_grp),
        .sel(dec.cfg), .wdata(bus_wdata), .q(cfg_q)
    );

    assign out_trig = wr_ok && ((dec.is_grp && dec.grp == 2'd0) ||
                                (!dec.is_grp && dec.cfg == CFG_DIR));

    gpio_out_change #(.W(W)) u_chg (
        .clk(clk), .rst(rst), .trig(out_trig),
        .data(grp_q[0]), .dir(cfg_q[0]), .chg(pin_chg)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && !bus_err) begin
            if (dec.is_grp) begin
                unique case (dec.grp)
                    2'd0:    bus_rdata = grp_q[0];
                    2'd1:    bus_rdata = grp_q[1];
                    default: bus_rdata = grp_q[2];
                endcase
            end else begin
                unique case (dec.cfg)
                    3'd0:    bus_rdata = cfg_q[0];
                    3'd1:    bus_rdata = cfg_q[1];
                    3'd2:    bus_rdata = cfg_q[2];
                    3'd3:    bus_rdata = cfg_q[3];
                    default: bus_rdata = cfg_q[4];
                endcase
            end
        end
    end

    assign pin_oe     = cfg_q[0];
    assign pin_out    = grp_q[0] & cfg_q[0];
    assign irq_mask_a = grp_q[1];
    assign irq_mask_b = grp_q[2];
    assign cfg_polar  = cfg_q[1];
    assign cfg_edge   = cfg_q[2];
    assign cfg_both   = cfg_q[3];
    assign cfg_inen   = cfg_q[4];

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && pin_out == '0 && irq_mask_a == '0 &&
                 irq_mask_b == '0 && cfg_inen == '0 && pin_chg == '0));
    a_r7_bad_size_flags: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && bus_size != SIZE_HALF) |-> bus_err);
    a_r7_bad_size_no_effect: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_size != SIZE_HALF) |=>
            ($stable(pin_out) && $stable(pin_oe) && $stable(irq_mask_a) &&
             $stable(irq_mask_b) && $stable(cfg_polar) && $stable(cfg_inen)));
    a_r8_past_map_flags: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && int'(bus_addr) > 4 * (NUM_REGS - 1)) |-> bus_err);
    a_r8_err_reads_zero: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> bus_rdata == '0);
    a_r10_chg_after_write: assert property (@(posedge clk) disable iff (rst)
        (pin_chg != '0) |-> $past(bus_wr));
    a_r9_inputs_undriven: assert property (@(posedge clk) disable iff (rst)
        (pin_out & ~pin_oe) == '0);
endmodule

// File: tb/gpio_regbank_test.sv
module gpio_regbank_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [6:0]   bus_addr = '0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]   bus_size = 2'd1;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata, pin_out, pin_oe, pin_chg;
    logic [W-1:0] irq_mask_a, irq_mask_b, cfg_polar, cfg_edge, cfg_both, cfg_inen;
    logic         bus_err;

    int n_cmp = 0, n_bad = 0;
    logic [W-1:0] m_grp [3];
    logic [W-1:0] m_cfg [5];
    logic [W-1:0] m_chg = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_regbank uut (.*);

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic model_err(logic [6:0] a, logic [1:0] sz);
        return (sz != 2'd1) || (a[1:0] != 2'b00) || (a > 7'h40);
    endfunction

    function automatic logic [W-1:0] model_read(logic [6:0] a);
        int idx = int'(a) / 4;
        if (idx < 12) return m_grp[idx / 4];
        return m_cfg[idx - 12];
    endfunction

    task automatic check_ports(string tag);
        chk({tag, " R9 pin_oe"}, pin_oe, m_cfg[0]);
        chk({tag, " R9 pin_out"}, pin_out, m_grp[0] & m_cfg[0]);
        chk({tag, " R10 pin_chg"}, pin_chg, m_chg);
        chk({tag, " R11 mask_a"}, irq_mask_a, m_grp[1]);
        chk({tag, " R11 mask_b"}, irq_mask_b, m_grp[2]);
        chk({tag, " R11 polar"}, cfg_polar, m_cfg[1]);
        chk({tag, " R11 edge"}, cfg_edge, m_cfg[2]);
        chk({tag, " R11 both"}, cfg_both, m_cfg[3]);
        chk({tag, " R11 inen"}, cfg_inen, m_cfg[4]);
    endtask

    // One bus cycle: drive at negedge, check combinational outputs, then model the edge.
    task automatic access(string tag, logic w, logic r, logic [6:0] a,
                          logic [1:0] sz, logic [W-1:0] d);
        logic e;
        logic [W-1:0] old_data;
        int idx;
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_size = sz; bus_wdata = d;
        #1;
        e = model_err(a, sz);
        if (w || r) chk({tag, " R7/R8 bus_err"}, {15'd0, bus_err}, {15'd0, e});
        if (r) chk({tag, " R2/R6/R8 rdata"}, bus_rdata, e ? '0 : model_read(a));
        @(posedge clk);
        old_data = m_grp[0];
        m_chg = '0;
        if (w && !e) begin
            idx = int'(a) / 4;
            if (idx < 12) begin
                case (idx % 4)
                    0: m_grp[idx/4] = d;
                    1: m_grp[idx/4] = m_grp[idx/4] & ~d;
                    2: m_grp[idx/4] = m_grp[idx/4] | d;
                    default: m_grp[idx/4] = m_grp[idx/4] ^ d;
                endcase
            end else m_cfg[idx-12] = d;
            if (idx < 4 || idx == 12) m_chg = (m_grp[0] ^ old_data) & m_cfg[0];
        end
        #1;
        check_ports(tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [6:0] a; logic [1:0] sz; logic w;
        for (int i = 0; i < 3; i++) m_grp[i] = '0;
        for (int i = 0; i < 5; i++) m_cfg[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1 check_ports("R1 reset");
        chk("R1 rdata idle", bus_rdata, '0);

        access("R2 data store", 1, 0, 7'h00, 1, 16'hA5A5);
        access("R9 data not driven", 0, 1, 7'h00, 1, 0);
        access("R10 dir write", 1, 0, 7'h30, 1, 16'hFF00);
        access("R5 data toggle", 1, 0, 7'h0C, 1, 16'h0F0F);
        access("R6 read toggle alias", 0, 1, 7'h0C, 1, 0);
        access("R3 data clear", 1, 0, 7'h04, 1, 16'hF000);
        access("R4 data set", 1, 0, 7'h08, 1, 16'h00FF);
        access("R2 mask_a store", 1, 0, 7'h10, 1, 16'h3C3C);
        access("R3 mask_a clear", 1, 0, 7'h14, 1, 16'h0FF0);
        access("R4 mask_b set", 1, 0, 7'h28, 1, 16'h8001);
        access("R5 mask_b toggle", 1, 0, 7'h2C, 1, 16'h8100);
        access("R6 read mask_b clear alias", 0, 1, 7'h24, 1, 0);
        access("R2 inen", 1, 0, 7'h40, 1, 16'h1234);
        access("R2 polar", 1, 0, 7'h34, 1, 16'h5555);
        access("R7 byte write ignored", 1, 0, 7'h00, 0, 16'hFFFF);
        access("R7 word read", 0, 1, 7'h10, 2, 0);
        access("R7 bad size past map", 1, 0, 7'h50, 3, 16'h1111);
        access("R8 past map write", 1, 0, 7'h44, 1, 16'hFFFF);
        access("R8 unaligned write", 1, 0, 7'h02, 1, 16'hFFFF);
        access("R8 past map read", 0, 1, 7'h7C, 1, 0);

        void'($urandom(32'd2024));
        for (int i = 0; i < 3000; i++) begin
            a  = ($urandom % 10 < 8) ? 7'(($urandom % 17) * 4) : 7'($urandom % 128);
            sz = ($urandom % 8 == 0) ? 2'($urandom % 4) : 2'd1;
            w  = $urandom % 2;
            access("R2-R11 random", w, !w, a, sz, 16'($urandom));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule